// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Page Buffer

This block is the slave side of a two-wire serial bus in front of a 128-byte, 8-bit-wide memory. It oversamples the clock and data lines with the system clock. It recognises START and STOP conditions, compares the first byte of each transfer with a fixed 7-bit device code, and pulls the data line low to acknowledge every byte it accepts.

A write transfer carries a word address and then data bytes. The data bytes collect in an eight-entry page buffer. The buffer reaches the array only when the master ends the transfer with STOP, and only if the write-enable level is high at that moment. A fixed busy interval follows each commit and stands in for the self-timed programming time. During that interval the slave ignores its own address.

Read transfers return the byte at the internal pointer. The read may start at the pointer's current value, or the master may first set the pointer with an address write followed by a repeated START. The read continues to later addresses for as long as the master acknowledges. A one-cycle pulse reports every accepted control byte to a neighbouring mode controller.

Top module: `tw_eeprom_slave`

## Requirements
- R1: The first byte after START is a control byte, sent MSB first. Its bits 7..1 are compared with the device code 1010000, and bit 0 selects read (1) or write (0). A matching byte is acknowledged (SDA held low through the ninth clock) unless a commit is busy. A byte that does not match is not acknowledged, and the slave then ignores all traffic until the next START.
- R2: `ctl_hit_o` is high for exactly one clock for each acknowledged control byte and never otherwise.
- R3: In a write transfer the byte after the control byte is the word address. It is acknowledged, and its low 7 bits load the pointer. Bit 7 is ignored.
- R4: Each data byte of a write is acknowledged and stored in the page buffer at the pointer's low 3 bits. Those 3 bits then advance and wrap within the 8-byte page, so a ninth or later byte overwrites an earlier one.
- R5: Buffered bytes do not reach the array before STOP. A read made through a repeated START before STOP returns the old contents. At STOP the buffered bytes are written to the page chosen by the word address.
- R6: If `wr_en_i` is low when STOP is seen, no array location changes and the buffer is discarded.
- R7: A committing STOP starts a busy interval of BUSY_CYC clocks. During that interval a control byte is not acknowledged and the slave never drives SDA.
- R8: A read sends the byte at the pointer, MSB first, and then increments the pointer, wrapping from 7Fh to 00h. A current-address read starts at the pointer left by the previous access, whether that access was a read or a write.
- R9: A random read (address write, repeated START, read control byte) returns data starting at the written address.
- R10: Reading continues at incrementing addresses while the master acknowledges. After a byte the master does not acknowledge, the slave releases SDA and stays idle until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| wr_en_i | input | 1 | Commit enable; low blocks all array writes at STOP |
| sda_oe_o | output | 1 | High pulls the data line low |
| ctl_hit_o | output | 1 | One-cycle pulse on an accepted control byte |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except to make START and STOP. They also assume that every bus level is held for several system clocks, so the synchroniser keeps the order of SCL and SDA edges. The bench master holds each bus phase for six clocks and changes data only in the low half of SCL. Every read burst ends with a not-acknowledged byte, so the slave never holds SDA low when the master issues STOP. Between a committing STOP and the next transfer the bench waits longer than the busy interval, except for the deliberate probe that R7 calls for.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA
   } tw_state_e;
endpackage

// File: rtl/tw_bus_cond.sv
module tw_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o,
   output logic sda_o
);
   logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
   logic scl_d, sda_d, scl_now, sda_now;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
         end else begin
            scl_sy <= scl_i;
            sda_sy <= sda_i;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
         end else begin
            scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
         end
      end
   end

   assign scl_now = scl_sy[SYNC_STAGES-1];
   assign sda_now = sda_sy[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_now;
         sda_d <= sda_now;
      end
   end

   assign scl_rise_o = scl_now & ~scl_d;
   assign scl_fall_o = ~scl_now & scl_d;
   assign start_o    = scl_now & scl_d & sda_d & ~sda_now;
   assign stop_o     = scl_now & scl_d & ~sda_d & sda_now;
   assign sda_o      = sda_now;
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
   parameter int PAGE_BYTES = 8,
   parameter int DATA_W     = 8,
   localparam int PG_W      = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic [PG_W-1:0]   wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PG_W-1:0]   rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_vld_o,
   output logic              any_o
);
   logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vld_q <= '0;
      else if (clr_i)
         vld_q <= '0;
      else if (wr_i)
         vld_q[wr_idx_i] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_i)
         slot_q[wr_idx_i] <= wr_data_i;
   end

   assign rd_data_o = slot_q[rd_idx_i];
   assign rd_vld_o  = vld_q[rd_idx_i];
   assign any_o     = |vld_q;
endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
   parameter int DEPTH  = 128,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i)
         cell_q[waddr_i] <= wdata_i;
      rdata_o <= cell_q[raddr_i];
   end
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
   import tw_pkg::*;
#(
   parameter int         MEM_DEPTH   = 128,
   parameter int         PAGE_BYTES  = 8,
   parameter int         BUSY_CYC    = 200,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_CODE    = 7'b1010000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wr_en_i,
   output logic sda_oe_o,
   output logic ctl_hit_o
);
   localparam int BYTE_W = 8;
   localparam int AW     = $clog2(MEM_DEPTH);
   localparam int PG_W   = $clog2(PAGE_BYTES);
   localparam int HI_W   = AW - PG_W;
   localparam int CNT_W  = $clog2(BUSY_CYC + 1);
   localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(PAGE_BYTES - 1);
   localparam logic [CNT_W-1:0] BUSY_TOP = CNT_W'(BUSY_CYC - 1);

   if ((1 << AW) != MEM_DEPTH || AW > BYTE_W) begin : g_bad_depth
      $error("MEM_DEPTH must be a power of two no larger than 256");
   end
   if (PAGE_BYTES < 2 || (1 << PG_W) != PAGE_BYTES || PAGE_BYTES >= MEM_DEPTH) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two below MEM_DEPTH");
   end
   if (BUSY_CYC < PAGE_BYTES) begin : g_bad_busy
      $error("BUSY_CYC must cover the page commit");
   end

   logic scl_rise, scl_fall, start_c, stop_c, sda_s;
   tw_state_e          state_q;
   logic [3:0]         bitcnt_q;
   logic               in_ack_q, sda_oe_q, hit_q, mack_q;
   logic [BYTE_W-1:0]  rx_sh_q, tx_sh_q, rd_q, slot_data;
   logic [AW-1:0]      ptr_q;
   logic [HI_W-1:0]    page_base_q;
   logic               busy_q, commit_on_q, slot_vld, buf_any;
   logic [CNT_W-1:0]   busy_cnt_q;
   logic [PG_W-1:0]    commit_idx_q;
   logic               evt_byte, buf_wr, buf_clr, commit_go, commit_end, mem_we;

   tw_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_c), .stop_o(stop_c), .sda_o(sda_s)
   );

   assign evt_byte   = (state_q != ST_IDLE) && !start_c && !stop_c && scl_fall
                       && !in_ack_q && (bitcnt_q == 4'd8);
   assign buf_wr     = evt_byte && (state_q == ST_WDATA);
   assign commit_go  = stop_c && buf_any && wr_en_i && !busy_q;
   assign commit_end = commit_on_q && (commit_idx_q == PG_LAST);
   assign buf_clr    = (evt_byte && (state_q == ST_ADDR)) || commit_end
                       || (stop_c && !wr_en_i && !busy_q);
   assign mem_we     = commit_on_q && slot_vld;

   tw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(BYTE_W)) buf_i (
      .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(buf_wr),
      .wr_idx_i(ptr_q[PG_W-1:0]), .wr_data_i(rx_sh_q),
      .rd_idx_i(commit_idx_q), .rd_data_o(slot_data),
      .rd_vld_o(slot_vld), .any_o(buf_any)
   );

   tw_mem #(.DEPTH(MEM_DEPTH), .DATA_W(BYTE_W)) mem_i (
      .clk(clk), .we_i(mem_we), .waddr_i({page_base_q, commit_idx_q}),
      .wdata_i(slot_data), .raddr_i(ptr_q), .rdata_o(rd_q)
   );

   // commit sequencer and busy interval
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_on_q  <= 1'b0;
         commit_idx_q <= '0;
         busy_q       <= 1'b0;
         busy_cnt_q   <= '0;
      end else if (commit_go) begin
         commit_on_q  <= 1'b1;
         commit_idx_q <= '0;
         busy_q       <= 1'b1;
         busy_cnt_q   <= BUSY_TOP;
      end else begin
         if (commit_on_q) begin
            commit_idx_q <= commit_idx_q + 1'b1;
            if (commit_end)
               commit_on_q <= 1'b0;
         end
         if (busy_q) begin
            if (busy_cnt_q == '0)
               busy_q <= 1'b0;
            else
               busy_cnt_q <= busy_cnt_q - 1'b1;
         end
      end
   end

   // bus protocol sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         bitcnt_q    <= '0;
         in_ack_q    <= 1'b0;
         sda_oe_q    <= 1'b0;
         hit_q       <= 1'b0;
         mack_q      <= 1'b0;
         rx_sh_q     <= '0;
         tx_sh_q     <= '0;
         ptr_q       <= '0;
         page_base_q <= '0;
      end else begin
         hit_q <= 1'b0;
         if (start_c) begin
            state_q  <= ST_CTRL;
            bitcnt_q <= '0;
            in_ack_q <= 1'b0;
            sda_oe_q <= 1'b0;
         end else if (stop_c) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            in_ack_q <= 1'b0;
            sda_oe_q <= 1'b0;
         end else if (state_q != ST_IDLE) begin
            if (scl_rise) begin
               if (!in_ack_q && bitcnt_q < 4'd8) begin
                  if (state_q != ST_RDATA)
                     rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_s};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end else if (in_ack_q && state_q == ST_RDATA) begin
                  mack_q <= ~sda_s;
               end
            end else if (scl_fall) begin
               if (in_ack_q) begin
                  in_ack_q <= 1'b0;
                  bitcnt_q <= '0;
                  if (state_q == ST_RDATA && mack_q) begin
                     tx_sh_q  <= rd_q;
                     sda_oe_q <= ~rd_q[BYTE_W-1];
                     ptr_q    <= ptr_q + 1'b1;
                  end else if (state_q == ST_RDATA) begin
                     state_q  <= ST_IDLE;
                     sda_oe_q <= 1'b0;
                  end else begin
                     sda_oe_q <= 1'b0;
                  end
               end else if (evt_byte) begin
                  in_ack_q <= 1'b1;
                  unique case (state_q)
                     ST_CTRL: begin
                        if (rx_sh_q[BYTE_W-1:1] == DEV_CODE && !busy_q) begin
                           sda_oe_q <= 1'b1;
                           hit_q    <= 1'b1;
                           mack_q   <= 1'b1;
                           state_q  <= rx_sh_q[0] ? ST_RDATA : ST_ADDR;
                        end else begin
                           in_ack_q <= 1'b0;
                           state_q  <= ST_IDLE;
                        end
                     end
                     ST_ADDR: begin
                        sda_oe_q    <= 1'b1;
                        ptr_q       <= rx_sh_q[AW-1:0];
                        page_base_q <= rx_sh_q[AW-1:PG_W];
                        state_q     <= ST_WDATA;
                     end
                     ST_WDATA: begin
                        sda_oe_q <= 1'b1;
                        ptr_q    <= {ptr_q[AW-1:PG_W], ptr_q[PG_W-1:0] + 1'b1};
                     end
                     default: sda_oe_q <= 1'b0;
                  endcase
               end else if (state_q == ST_RDATA && bitcnt_q != 4'd0) begin
                  tx_sh_q  <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                  sda_oe_q <= ~tx_sh_q[BYTE_W-2];
               end
            end
         end
      end
   end

   assign sda_oe_o  = sda_oe_q;
   assign ctl_hit_o = hit_q;
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk #(
   parameter int PTR_W = 7,
   parameter int PG_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input tw_pkg::tw_state_e state,
   input logic              sda_oe,
   input logic              ctl_hit,
   input logic              busy,
   input logic              mem_we,
   input logic              commit_on,
   input logic              wr_en,
   input logic [PTR_W-1:0]  ptr
);
   a_r2_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |=> !ctl_hit);

   a_r2_hit_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |-> sda_oe);

   a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   a_r5_write_outside_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (state == tw_pkg::ST_IDLE));

   a_r6_commit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(commit_on) |-> $past(wr_en));

   a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == tw_pkg::ST_IDLE) |-> !sda_oe);

   a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (state == tw_pkg::ST_WDATA && $past(state) == tw_pkg::ST_WDATA)
      |-> $stable(ptr[PTR_W-1:PG_W]));
endmodule

bind tw_eeprom_slave tw_eeprom_chk #(.PTR_W(AW), .PG_W(PG_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .state(state_q), .sda_oe(sda_oe_q),
   .ctl_hit(hit_q), .busy(busy_q), .mem_we(mem_we),
   .commit_on(commit_on_q), .wr_en(wr_en_i), .ptr(ptr_q)
);

// File: tb/tw_eeprom_slave_tb.sv
`timescale 1ns/1ps
module tw_eeprom_slave_tb_top;
   localparam int Q    = 6;
   localparam int BUSY = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, wr_en = 1'b1;
   logic sda_line, sda_oe_o, ctl_hit_o;
   int   vec = 0, bad = 0, hits = 0, exp_hits = 0;
   bit   done = 1'b0;

   logic [7:0] ref_mem [128];
   logic [7:0] pend [8];
   bit         pend_v [8];
   int         ref_ptr = 0, pend_base = 0;

   always #4 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe_o;

   tw_eeprom_slave #(.BUSY_CYC(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .wr_en_i(wr_en), .sda_oe_o(sda_oe_o), .ctl_hit_o(ctl_hit_o)
   );

   always @(negedge clk) if (rst_n && ctl_hit_o) hits++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
      m_sda = 1'b0; wait_q(); m_scl = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_q(); m_scl = 1'b1; wait_q();
      m_sda = 1'b1; wait_q();
   endtask

   task automatic send_bit(input bit b);
      m_sda = b; wait_q(); m_scl = 1'b1; wait_q(); wait_q(); m_scl = 1'b0; wait_q();
   endtask

   task automatic read_bit(output bit b);
      m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q(); b = sda_line;
      wait_q(); m_scl = 1'b0; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      read_bit(s);
      ack = ~s;
   endtask

   task automatic recv_byte(output logic [7:0] v, input bit mack);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         read_bit(s);
         v[i] = s;
      end
      send_bit(~mack);
   endtask

   task automatic model_clear();
      for (int i = 0; i < 8; i++) pend_v[i] = 1'b0;
   endtask

   task automatic model_stop();
      if (wr_en)
         for (int i = 0; i < 8; i++)
            if (pend_v[i]) ref_mem[pend_base | i] = pend[i];
      model_clear();
   endtask

   task automatic ctrl(input logic [7:0] cb, input string tag);
      bit ack;
      send_byte(cb, ack);
      exp_hits++;
      chk(ack, {tag, " R1 control ack"}, ack, 1);
      chk(hits == exp_hits, {tag, " R2 hit pulse count"}, hits, exp_hits);
   endtask

   task automatic set_addr(input int addr, input string tag);
      bit ack;
      send_byte(addr[7:0], ack);
      chk(ack, {tag, " R3 address ack"}, ack, 1);
      ref_ptr = addr & 8'h7F;
      pend_base = ref_ptr & 8'h78;
      model_clear();
   endtask

   task automatic put_data(input int n, input int seed, input string tag);
      bit ack;
      logic [7:0] d;
      for (int i = 0; i < n; i++) begin
         d = 8'((seed + i * 29) & 255);
         send_byte(d, ack);
         chk(ack, {tag, " R4 data ack"}, ack, 1);
         pend[ref_ptr & 7] = d;
         pend_v[ref_ptr & 7] = 1'b1;
         ref_ptr = pend_base | ((ref_ptr + 1) & 7);
      end
   endtask

   task automatic get_data(input int n, input string tag);
      logic [7:0] v;
      for (int i = 0; i < n; i++) begin
         recv_byte(v, i != n - 1);
         chk(v == ref_mem[ref_ptr], {tag, " R8 read data"}, v, ref_mem[ref_ptr]);
         ref_ptr = (ref_ptr + 1) & 8'h7F;
      end
      chk(sda_oe_o == 1'b0, {tag, " R10 released after nack"}, sda_oe_o, 0);
   endtask

   task automatic txn_write(input int addr, input int n, input int seed, input bit probe);
      bit ack;
      bus_start(); ctrl(8'hA0, "wr"); set_addr(addr, "wr"); put_data(n, seed, "wr");
      bus_stop(); model_stop();
      if (probe) begin
         bus_start(); send_byte(8'hA0, ack);
         chk(!ack, "R7 no ack while busy", ack, 0);
         chk(hits == exp_hits, "R7 R2 no hit while busy", hits, exp_hits);
         bus_stop();
      end
      repeat (BUSY + 40) @(posedge clk);
      #1;
   endtask

   task automatic txn_read(input bit random, input int addr, input int n, input string tag);
      if (random) begin
         bus_start(); ctrl(8'hA0, tag); set_addr(addr, tag);
      end
      bus_start(); ctrl(8'hA1, tag); get_data(n, tag);
      bus_stop(); wait_q();
   endtask

   initial begin
      bit ack;
      logic [7:0] v;
      model_clear();
      repeat (5) @(posedge clk);
      #1;
      chk(sda_oe_o == 1'b0, "reset sda released", sda_oe_o, 0);
      chk(ctl_hit_o == 1'b0, "reset no hit", ctl_hit_o, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;

      // fill the array page by page; first write probes the busy interval (R7)
      for (int p = 0; p < 16; p++) txn_write(p * 8, 8, p * 11 + 3, p == 0);

      // R9 random read with sequential continuation (R10)
      txn_read(1'b1, 8'h10, 3, "R9 random");
      // R8 current-address read continues from the pointer
      txn_read(1'b0, 0, 2, "R8 current");
      // R8 wrap from 7Fh to 00h
      txn_read(1'b1, 8'h7E, 4, "R8 wrap");
      // R3 bit 7 of the word address is ignored
      txn_read(1'b1, 8'h93, 1, "R3 high bit");

      // R4 page wrap: ten bytes from 25h land in 20h..27h
      txn_write(8'h25, 10, 77, 1'b0);
      txn_read(1'b1, 8'h20, 8, "R4 page wrap");
      // R8 current read right after a write uses the pointer the write left
      txn_write(8'h31, 2, 150, 1'b0);
      txn_read(1'b0, 0, 1, "R8 after write");

      // R5 buffered data not visible before STOP
      bus_start(); ctrl(8'hA0, "R5"); set_addr(8'h40, "R5"); put_data(2, 200, "R5");
      bus_start(); ctrl(8'hA1, "R5");
      recv_byte(v, 1'b0);
      chk(v == ref_mem[ref_ptr], "R5 old data before stop", v, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) & 8'h7F;
      bus_stop(); model_stop();
      repeat (BUSY + 40) @(posedge clk);
      #1;
      txn_read(1'b1, 8'h40, 3, "R5 committed");

      // R6 write with commit enable low
      wr_en = 1'b0;
      txn_write(8'h50, 4, 9, 1'b0);
      wr_en = 1'b1;
      txn_read(1'b1, 8'h50, 4, "R6 protected");

      // R1 wrong device code is ignored until the next START
      bus_start();
      send_byte(8'hA2, ack);
      chk(!ack, "R1 wrong code nack", ack, 0);
      chk(hits == exp_hits, "R1 R2 no hit on wrong code", hits, exp_hits);
      send_byte(8'h10, ack);
      chk(!ack, "R1 ignored until start", ack, 0);
      bus_stop(); wait_q();
      txn_read(1'b0, 0, 1, "R1 pointer kept");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         vec++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end
endmodule